// File: doc/BRIEF.md
# Lock Acquirer Prediction Table

This block watches a stream of lock acquisitions, each tagged with a lock identifier and the thread that took the lock. From that history it guesses which thread will take a given lock next. Software-visible locks outnumber the table rows. Each lock therefore maps onto a row through the low bits of its identifier. Locks that share those bits share one row, so a new lock name starts from history that already exists.

Each row keeps five things: whether it has ever been written, the first thread that acquired it, the thread that acquired it most recently, a saturating acquisition counter for every thread, and a saturating weight for every ordered pair of consecutive acquirers. A two-bit policy input chooses which history answers a query. The query path is combinational, so the prediction reflects the table as it stood before any acquire in the same cycle.

Top module: `lock_pred_table`

## Requirements
- R1: With policy 0, the prediction is the thread of the first acquisition recorded in the queried row.
- R2: With policy 1, the prediction is the thread of the most recent acquisition recorded in the queried row.
- R3: With policy 2, the prediction is the thread whose acquisition counter in the queried row is largest.
- R4: Every acquisition of a row that already has history adds one to the weight of the edge from the row's previous acquirer to the new acquirer. This includes the case where the same thread acquires twice. With policy 3, the prediction is the target of the heaviest edge leaving the row's latest acquirer. If every edge leaving that acquirer has zero weight, the valid output is low.
- R5: When counters (policy 2) or edge weights (policy 3) tie, the lowest-numbered thread wins.
- R6: The row is selected by the low log2(ENTRIES) bits of the lock ID, which are 3 bits by default. Two lock IDs that differ only above those bits read and write the same row.
- R7: Counters and edge weights are CW bits wide (4 by default). Once a value reaches 15 it holds there and never wraps.
- R8: A query on a row that has no recorded acquisition drives the valid output low, whatever the policy.
- R9: An acquire changes the table at the next rising clock edge. A query in the same cycle returns the result from the earlier state.
- R10: While the synchronous reset is high at a clock edge, every row, counter and weight is cleared, and every query afterwards returns valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acq_vld | input | 1 | An acquisition is reported this cycle |
| acq_lock | input | LOCK_W | Lock ID of the acquisition |
| acq_tid | input | log2(THREADS) | Thread that acquired the lock |
| qry_lock | input | LOCK_W | Lock ID being queried |
| policy | input | 2 | 0 first, 1 last, 2 most frequent, 3 heaviest handoff |
| pred_vld | output | 1 | Prediction is meaningful |
| pred_tid | output | log2(THREADS) | Predicted next acquirer |

## Verification
The assertions take for granted that the reset is held for at least one clock edge before normal operation. They also take for granted that the query and policy inputs change only between edges, so the prediction is compared against the table as seen at that edge. The bench meets both conditions. It drives every input on the falling edge and samples the outputs shortly afterwards. It asserts reset from time zero, and while it pushes long runs of acquisitions into a row it points the query at a different row.

// File: rtl/lock_pred_table.sv
module lock_pred_table #(
  parameter int ENTRIES = 8,
  parameter int THREADS = 4,
  parameter int CW      = 4,
  parameter int LOCK_W  = 16,
  localparam int IW = $clog2(ENTRIES),
  localparam int TW = $clog2(THREADS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acq_vld,
  input  logic [LOCK_W-1:0] acq_lock,
  input  logic [TW-1:0]     acq_tid,
  input  logic [LOCK_W-1:0] qry_lock,
  input  logic [1:0]        policy,
  output logic              pred_vld,
  output logic [TW-1:0]     pred_tid
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic          seen  [ENTRIES];
  logic [TW-1:0] first [ENTRIES];
  logic [TW-1:0] last  [ENTRIES];
  logic [CW-1:0] cnt   [ENTRIES][THREADS];
  logic [CW-1:0] wt    [ENTRIES][THREADS][THREADS];

  wire [IW-1:0] aidx = acq_lock[IW-1:0];
  wire [IW-1:0] qidx = qry_lock[IW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < ENTRIES; e++) begin
        seen[e]  <= 1'b0;
        first[e] <= '0;
        last[e]  <= '0;
        for (int a = 0; a < THREADS; a++) begin
          cnt[e][a] <= '0;
          for (int b = 0; b < THREADS; b++) wt[e][a][b] <= '0;
        end
      end
    end else if (acq_vld) begin
      seen[aidx] <= 1'b1;
      last[aidx] <= acq_tid;
      if (!seen[aidx]) first[aidx] <= acq_tid;
      if (cnt[aidx][acq_tid] != CMAX)
        cnt[aidx][acq_tid] <= cnt[aidx][acq_tid] + 1'b1;
      if (seen[aidx] && wt[aidx][last[aidx]][acq_tid] != CMAX)
        wt[aidx][last[aidx]][acq_tid] <= wt[aidx][last[aidx]][acq_tid] + 1'b1;
    end
  end

  logic [CW-1:0] best_c, best_w;
  logic [TW-1:0] tid_c, tid_w;

  always_comb begin
    best_c = '0; tid_c = '0;
    best_w = '0; tid_w = '0;
    for (int t = 0; t < THREADS; t++) begin
      if (cnt[qidx][t] > best_c) begin
        best_c = cnt[qidx][t];
        tid_c  = TW'(t);
      end
      if (wt[qidx][last[qidx]][t] > best_w) begin
        best_w = wt[qidx][last[qidx]][t];
        tid_w  = TW'(t);
      end
    end
    case (policy)
      2'd0:    begin pred_vld = seen[qidx];                  pred_tid = first[qidx]; end
      2'd1:    begin pred_vld = seen[qidx];                  pred_tid = last[qidx];  end
      2'd2:    begin pred_vld = seen[qidx] && best_c != '0;  pred_tid = tid_c;       end
      default: begin pred_vld = seen[qidx] && best_w != '0;  pred_tid = tid_w;       end
    endcase
  end

  logic chk_ok;
  always_ff @(posedge clk) chk_ok <= !rst;

  // R10
  reset_clears_chk: assert property (@(posedge clk) rst |=> !pred_vld);

  // R9
  hold_without_acq_chk: assert property (@(posedge clk) disable iff (rst || !chk_ok)
    !$past(acq_vld) && $stable(qry_lock) && $stable(policy)
      |-> $stable(pred_vld) && $stable(pred_tid));

  // R9
  visible_after_acq_chk: assert property (@(posedge clk) disable iff (rst || !chk_ok)
    $past(acq_vld) && qry_lock[IW-1:0] == $past(acq_lock[IW-1:0]) && policy != 2'd3
      |-> pred_vld);

  // R2
  last_follows_acq_chk: assert property (@(posedge clk) disable iff (rst || !chk_ok)
    $past(acq_vld) && qry_lock[IW-1:0] == $past(acq_lock[IW-1:0]) && policy == 2'd1
      |-> pred_tid == $past(acq_tid));

  for (genvar e = 0; e < ENTRIES; e++) begin : g_sat
    for (genvar t = 0; t < THREADS; t++) begin : g_thr
      // R7
      no_wrap_chk: assert property (@(posedge clk) disable iff (rst || !chk_ok)
        cnt[e][t] >= $past(cnt[e][t]));
    end
  end
endmodule

// File: tb/lock_pred_table_test.sv
`timescale 1ns/1ps
module lock_pred_table_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acq_vld = 1'b0;
  logic [15:0] acq_lock = '0;
  logic [1:0]  acq_tid = '0;
  logic [15:0] qry_lock = '0;
  logic [1:0]  policy = '0;
  logic        pred_vld;
  logic [1:0]  pred_tid;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  lock_pred_table uut (.clk, .rst, .acq_vld, .acq_lock, .acq_tid,
                       .qry_lock, .policy, .pred_vld, .pred_tid);

  typedef struct packed {
    logic        av;
    logic [15:0] al;
    logic [1:0]  at;
    logic [15:0] ql;
    logic [1:0]  pol;
    logic        ev;
    logic [1:0]  et;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'd0, 2'd0, 16'd5,  2'd1, 1'b0, 2'd0},
    '{1'b1, 16'd5, 2'd2, 16'd5,  2'd0, 1'b0, 2'd0},
    '{1'b1, 16'd5, 2'd1, 16'd5,  2'd0, 1'b1, 2'd2},
    '{1'b1, 16'd5, 2'd1, 16'd5,  2'd1, 1'b1, 2'd1},
    '{1'b0, 16'd0, 2'd0, 16'd5,  2'd2, 1'b1, 2'd1},
    '{1'b0, 16'd0, 2'd0, 16'd5,  2'd3, 1'b1, 2'd1},
    '{1'b1, 16'd5, 2'd3, 16'd13, 2'd0, 1'b1, 2'd2},
    '{1'b0, 16'd0, 2'd0, 16'd5,  2'd3, 1'b0, 2'd0},
    '{1'b1, 16'd5, 2'd2, 16'd5,  2'd1, 1'b1, 2'd3},
    '{1'b0, 16'd0, 2'd0, 16'd5,  2'd2, 1'b1, 2'd1},
    '{1'b0, 16'd0, 2'd0, 16'd5,  2'd3, 1'b1, 2'd1},
    '{1'b1, 16'd2, 2'd0, 16'd2,  2'd2, 1'b0, 2'd0},
    '{1'b0, 16'd0, 2'd0, 16'd2,  2'd2, 1'b1, 2'd0},
    '{1'b0, 16'd0, 2'd0, 16'd3,  2'd0, 1'b0, 2'd0}
  };
  string tags [NV] = '{"R10", "R9", "R1", "R2", "R3", "R4", "R6",
                       "R4", "R2", "R5", "R4", "R8", "R3", "R8"};

  task automatic check(input string req, input logic ev, input logic [1:0] et);
    tests++;
    if (pred_vld !== ev || (ev && pred_tid !== et)) begin
      fails++;
      $display("FAIL %s: got vld=%0b tid=%0d, expected vld=%0b tid=%0d",
               req, pred_vld, pred_tid, ev, et);
    end
  endtask

  task automatic acq(input logic [15:0] l, input logic [1:0] t);
    @(negedge clk);
    acq_vld = 1'b1; acq_lock = l; acq_tid = t;
    qry_lock = 16'd0; policy = 2'd0;
  endtask

  task automatic ask(input logic [15:0] l, input logic [1:0] p);
    @(negedge clk);
    acq_vld = 1'b0; qry_lock = l; policy = p;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      acq_vld = VECS[i].av; acq_lock = VECS[i].al; acq_tid = VECS[i].at;
      qry_lock = VECS[i].ql; policy = VECS[i].pol;
      #1;
      check(tags[i], VECS[i].ev, VECS[i].et);
    end

    // R7 counters: thread 3 stops at 15, thread 1 reaches 15, tie goes low
    for (int i = 0; i < 20; i++) acq(16'd6, 2'd3);
    for (int i = 0; i < 15; i++) acq(16'd6, 2'd1);
    ask(16'd6, 2'd2);
    check("R7", 1'b1, 2'd1);

    // R7 weights: 1->1 stops at 15, 1->0 reaches 15, tie goes low
    for (int i = 0; i < 17; i++) acq(16'd7, 2'd1);
    for (int i = 0; i < 15; i++) begin
      acq(16'd7, 2'd0);
      acq(16'd7, 2'd1);
    end
    ask(16'd7, 2'd3);
    check("R7", 1'b1, 2'd0);
    ask(16'd7, 2'd1);
    check("R2", 1'b1, 2'd1);

    // R10: synchronous reset wipes history
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    ask(16'd5, 2'd1);
    check("R10", 1'b0, 2'd0);
    ask(16'd6, 2'd2);
    check("R10", 1'b0, 2'd0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule